// File: doc/BRIEF.md
# Buffered-Reload Up-Counter Timer

The block is an up-counting timer with two pin outputs: one output-compare pin driven by a selectable action on a compare match, and one edge-aligned PWM pin. Software never writes the live timing values directly. The start value, the wrap value (modulo) and both compare values go into shadow registers through a simple write port. The output-compare action goes through the same shadow path. A synchronization step copies the shadow contents into the active registers that steer the counter and the pins.

The software trigger sets off that copy in one of two ways. With the restart option set, the copy happens at once and the counter jumps back to the start value. With the restart option clear, the counter keeps running and the copy waits for an enabled loading point. There are two such points: the counter at its start value and the counter at its modulo. A running timer can therefore take new values at a clean period boundary without disturbing the PWM period.

Top module: `sync_reload_timer`

## Requirements
- R1: When the restart option is set, a trigger write makes `count` equal the buffered start value on the next cycle. All shadow values become active on that same edge, and `trigPending` stays 0.
- R2: When the restart option is clear, a trigger write sets `trigPending` to 1 and the counter continues its normal sequence. The shadow values do not become active at the trigger.
- R3: The shadow values are copied on a clock edge where `trigPending` is 1 and an enabled loading point is reached. The minimum point is `count` equal to the active start value, and the maximum point is `count` at or above the active modulo. The two points are enabled independently. With neither point enabled, a pending trigger stays pending and nothing is copied.
- R4: The output-compare action code is 0 for no action, 1 for drive high, 2 for drive low and 3 for invert. The action is applied to `ocPin` on the cycle after `count` equals the active compare value. A compare value above the modulo never matches, so `ocPin` keeps its level.
- R5: Shadow writes that are not followed by a trigger never change the active values. A later write to the same shadow register replaces the earlier one before the copy.
- R6: With the restart option clear and the maximum point enabled, a compare value that is written and triggered in the middle of a period takes effect only in the following period.
- R7: `pwmPin` is high while `count` is below the active PWM compare value and low otherwise. It follows `count` with no extra register. Triggers with the restart option clear do not alter the PWM period.
- R8: `count` increments by one each cycle. On the cycle after it reaches the active modulo, it returns to the start value that is active after that edge.
- R9: `trigPending` returns to 0 on the edge where the deferred copy happens, unless a new trigger is written in that same cycle.
- R10: A change of output-compare action becomes active only through the same copy as the compare value.
- R11: Write addresses are: 0 start value, 1 modulo, 2 output-compare value, 3 PWM compare value, 4 action code in bits 1:0, 5 sync control, 6 trigger. Sync control bits take effect immediately: bit 0 is the restart option, bit 1 enables the minimum point, bit 2 enables the maximum point. Writing address 6 with bit 0 set issues a trigger.
- R12: After reset: `count` is 0, the start value is 0, the modulo is `RESET_MOD`, the output-compare value is all ones, the PWM compare value is 0, the action is 0, and all sync bits are 0. `ocPin`, `pwmPin` and `trigPending` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | CNT_W | Register write data |
| count | output | CNT_W | Current counter value |
| ocPin | output | 1 | Output-compare pin |
| pwmPin | output | 1 | Edge-aligned PWM pin |
| trigPending | output | 1 | Software trigger bit, cleared when its copy is applied |

## Verification
The bench builds the timer with an 8-bit counter and a reset modulo of 255, then programs a start value of 2 and a modulo of 9. Each period is therefore eight cycles. This makes many wraps, both loading points and deferred copies reachable within a few hundred cycles. The 8-bit width also lets a compare value of 200 sit above the modulo, which exercises the never-matching case. The bench also changes the start value and modulo through a restart so that the wrap is checked against new values.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int ADDR_W  = 3;
  localparam int NUM_VAL = 4;  // start, modulo, oc compare, pwm compare

  localparam logic [ADDR_W-1:0] ADDR_START = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MOD   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_OCV   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PWMV  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_ACT   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_SYNC  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_TRIG  = 3'd6;

  typedef enum logic [1:0] {
    OC_NONE = 2'd0,
    OC_HIGH = 2'd1,
    OC_LOW  = 2'd2,
    OC_FLIP = 2'd3
  } ocAct_e;

  typedef struct packed {
    logic load;     // copy shadow into active
    logic restart;  // counter back to buffered start value
  } syncStrb_t;
endpackage

// File: rtl/srt_ctrl.sv
module srt_ctrl
  import srt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [2:0]        wrBits,
  input  logic              atMin,
  input  logic              atMax,
  output syncStrb_t         strb,
  output logic              pending
);
  logic restartOptQ, minEnQ, maxEnQ, pendQ;
  logic trigWr, immediate, pointHit;

  assign trigWr    = wrEn && (wrAddr == ADDR_TRIG) && wrBits[0];
  assign immediate = trigWr && restartOptQ;
  assign pointHit  = pendQ && ((minEnQ && atMin) || (maxEnQ && atMax));

  always_comb begin
    strb.restart = immediate;
    strb.load    = immediate || pointHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      restartOptQ <= 1'b0;
      minEnQ      <= 1'b0;
      maxEnQ      <= 1'b0;
      pendQ       <= 1'b0;
    end else begin
      if (wrEn && wrAddr == ADDR_SYNC) begin
        restartOptQ <= wrBits[0];
        minEnQ      <= wrBits[1];
        maxEnQ      <= wrBits[2];
      end
      if (trigWr && !restartOptQ) pendQ <= 1'b1;
      else if (strb.load)         pendQ <= 1'b0;
    end
  end

  assign pending = pendQ;

  AST_DEFER_SETS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (trigWr && !restartOptQ) |=> pendQ); // R2
  AST_PEND_HOLD_NO_POINT: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !minEnQ && !maxEnQ && !trigWr) |=> pendQ); // R3
  AST_PEND_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && strb.load && !trigWr) |=> !pendQ); // R9
endmodule

// File: rtl/srt_dp.sv
module srt_dp
  import srt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RESET_MOD = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  syncStrb_t         strb,
  output logic              atMin,
  output logic              atMax,
  output logic [CNT_W-1:0]  count,
  output logic              ocPin,
  output logic              pwmPin
);
  localparam int IDX_START = 0;
  localparam int IDX_MOD   = 1;
  localparam int IDX_OCV   = 2;
  localparam int IDX_PWMV  = 3;

  logic [CNT_W-1:0] bufQ [NUM_VAL];
  logic [CNT_W-1:0] actQ [NUM_VAL];
  ocAct_e           bufActQ, actActQ;
  logic [CNT_W-1:0] cntQ, wrapVal;
  logic             ocQ;

  function automatic logic [CNT_W-1:0] rstVal(int idx);
    case (idx)
      IDX_MOD: return RESET_MOD;
      IDX_OCV: return '1;
      default: return '0;
    endcase
  endfunction

  // shadow and active value registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_VAL; i++) begin
        bufQ[i] <= rstVal(i);
        actQ[i] <= rstVal(i);
      end
      bufActQ <= OC_NONE;
      actActQ <= OC_NONE;
    end else begin
      for (int i = 0; i < NUM_VAL; i++) begin
        if (wrEn && wrAddr == ADDR_W'(i)) bufQ[i] <= wrData;
        if (strb.load) actQ[i] <= bufQ[i];
      end
      if (wrEn && wrAddr == ADDR_ACT) bufActQ <= ocAct_e'(wrData[1:0]);
      if (strb.load) actActQ <= bufActQ;
    end
  end

  assign atMin   = (cntQ == actQ[IDX_START]);
  assign atMax   = (cntQ >= actQ[IDX_MOD]);
  assign wrapVal = strb.load ? bufQ[IDX_START] : actQ[IDX_START];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntQ <= '0;
    else if (strb.restart) cntQ <= bufQ[IDX_START];
    else if (atMax)        cntQ <= wrapVal;
    else                   cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ocQ <= 1'b0;
    else if (cntQ == actQ[IDX_OCV]) begin
      case (actActQ)
        OC_HIGH: ocQ <= 1'b1;
        OC_LOW:  ocQ <= 1'b0;
        OC_FLIP: ocQ <= ~ocQ;
        default: ocQ <= ocQ;
      endcase
    end
  end

  assign count  = cntQ;
  assign ocPin  = ocQ;
  assign pwmPin = (cntQ < actQ[IDX_PWMV]);

  AST_RESTART_TO_START: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (cntQ == $past(bufQ[IDX_START]))); // R1
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(actQ[IDX_OCV]) && $stable(actQ[IDX_PWMV]) && $stable(actQ[IDX_MOD]))); // R5
  AST_ACTION_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(actActQ)); // R10
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.restart && cntQ < actQ[IDX_MOD]) |=> (cntQ == $past(cntQ) + 1'b1)); // R8
  AST_OC_NEVER_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (actQ[IDX_OCV] > actQ[IDX_MOD] && cntQ <= actQ[IDX_MOD]) |=> $stable(ocQ)); // R4
endmodule

// File: rtl/sync_reload_timer.sv
module sync_reload_timer
  import srt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RESET_MOD = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             ocPin,
  output logic             pwmPin,
  output logic             trigPending
);
  syncStrb_t strb;
  logic      atMin, atMax;

  srt_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrBits  (wrData[2:0]),
    .atMin   (atMin),
    .atMax   (atMax),
    .strb    (strb),
    .pending (trigPending)
  );

  srt_dp #(.CNT_W(CNT_W), .RESET_MOD(RESET_MOD)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strb   (strb),
    .atMin  (atMin),
    .atMax  (atMax),
    .count  (count),
    .ocPin  (ocPin),
    .pwmPin (pwmPin)
  );
endmodule

// File: tb/sync_reload_timer_test.sv
module sync_reload_timer_test;
  localparam int W = 8;
  localparam int SIG_CNT = 0, SIG_OC = 1, SIG_PWM = 2, SIG_PEND = 3;

  logic         clk = 1'b0;
  logic         rstN;
  logic         wrEn;
  logic [2:0]   wrAddr;
  logic [W-1:0] wrData;
  logic [W-1:0] count;
  logic         ocPin, pwmPin, trigPending;

  always #2 clk = ~clk;  // 250 MHz

  sync_reload_timer #(.CNT_W(W), .RESET_MOD(8'd255)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .ocPin(ocPin), .pwmPin(pwmPin), .trigPending(trigPending)
  );

  typedef struct {
    string tag;
    int    sig;
    int    exp;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  function automatic int actual(int sig);
    case (sig)
      SIG_CNT: return int'(count);
      SIG_OC:  return int'(ocPin);
      SIG_PWM: return int'(pwmPin);
      default: return int'(trigPending);
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (actual(it.sig) != it.exp) begin
          errors++;
          $display("FAIL %s sig=%0d actual=%0d expected=%0d", it.tag, it.sig, actual(it.sig), it.exp);
        end
      end
    end
  end

  task automatic expectSig(string tag, int sig, int exp);
    q.push_back('{tag, sig, exp});
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(logic [2:0] a, int d);
    wrEn = 1'b1; wrAddr = a; wrData = W'(d);
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic waitCnt(int v);
    int guard = 0;
    while (int'(count) != v) begin
      tick(1);
      guard++;
      if (guard > 400) begin
        checks++; errors++;
        $display("FAIL waitCnt actual=%0d expected=%0d", count, v);
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ocRef;
    int e;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    tick(3);
    rstN = 1'b1;
    expectSig("R12 count", SIG_CNT, 0);
    expectSig("R12 oc", SIG_OC, 0);
    expectSig("R12 pwm", SIG_PWM, 0);
    expectSig("R12 pend", SIG_PEND, 0);

    // R11 map: start 2, mod 9, pwm 5, oc 4 with invert action, restart option
    wr(3'd0, 2); wr(3'd1, 9); wr(3'd3, 5); wr(3'd2, 4); wr(3'd4, 3);
    wr(3'd5, 1); wr(3'd6, 1);
    expectSig("R1 restart count", SIG_CNT, 2);
    expectSig("R1 no pend", SIG_PEND, 0);
    expectSig("R7 pwm high", SIG_PWM, 1);
    tick(3);
    expectSig("R8 count step", SIG_CNT, 5);
    expectSig("R4 invert first", SIG_OC, 1);
    expectSig("R7 pwm low", SIG_PWM, 0);
    tick(5);
    expectSig("R8 wrap", SIG_CNT, 2);
    tick(3);
    expectSig("R4 invert second", SIG_OC, 0);

    // R5 / R10: shadow writes without trigger, second oc write overwrites
    wr(3'd2, 7); wr(3'd4, 1); wr(3'd2, 6);
    for (int p = 0; p < 2; p++) begin
      waitCnt(3);
      ocRef = int'(ocPin);
      tick(2);
      expectSig("R10 old action kept", SIG_OC, 1 - ocRef);
      tick(3);
      expectSig("R5 shadow not active", SIG_OC, 1 - ocRef);
    end

    // R2 / R3: deferred trigger with no loading point
    wr(3'd5, 0);
    e = int'(count);
    wr(3'd6, 1);
    e = (e >= 9) ? 2 : e + 1;
    expectSig("R2 pend set", SIG_PEND, 1);
    expectSig("R2 count continues", SIG_CNT, e);
    tick(20);
    expectSig("R3 no point stays pending", SIG_PEND, 1);

    // R3 / R9: enable max point
    wr(3'd5, 4);
    waitCnt(9);
    expectSig("R2 pend before point", SIG_PEND, 1);
    tick(1);
    expectSig("R9 pend cleared", SIG_PEND, 0);
    expectSig("R8 wrap at point", SIG_CNT, 2);
    tick(5);
    expectSig("R4 drive high at 6", SIG_OC, 1);

    // R6: mid-period write takes effect next period
    waitCnt(2);
    wr(3'd2, 7); wr(3'd4, 2); wr(3'd6, 1);
    tick(3);
    expectSig("R6 count", SIG_CNT, 8);
    expectSig("R6 old compare this period", SIG_OC, 1);
    expectSig("R6 pend", SIG_PEND, 1);
    waitCnt(9);
    tick(1);
    expectSig("R6 pend cleared", SIG_PEND, 0);
    tick(6);
    expectSig("R6 drive low next period", SIG_OC, 0);

    // R3: minimum loading point only
    wr(3'd5, 2); wr(3'd4, 1); wr(3'd6, 1);
    expectSig("R3 min pend", SIG_PEND, 1);
    waitCnt(2);
    expectSig("R3 pend at min", SIG_PEND, 1);
    tick(1);
    expectSig("R3 min load", SIG_PEND, 0);
    tick(5);
    expectSig("R3 new action active", SIG_OC, 1);

    // R7: PWM period unchanged by non-restart triggers
    wr(3'd5, 4);
    e = int'(count);
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j <= k % 3; j++) begin
        tick(1);
        e = (e >= 9) ? 2 : e + 1;
        expectSig("R7 count steady", SIG_CNT, e);
        expectSig("R7 pwm steady", SIG_PWM, (e < 5) ? 1 : 0);
      end
      wr(3'd6, 1);
      e = (e >= 9) ? 2 : e + 1;
      expectSig("R7 count after trigger", SIG_CNT, e);
    end

    // R1: restart with new start and modulo
    wr(3'd0, 3); wr(3'd1, 12); wr(3'd5, 1); wr(3'd6, 1);
    expectSig("R1 new start", SIG_CNT, 3);
    expectSig("R1 pend zero", SIG_PEND, 0);
    tick(9);
    expectSig("R8 new modulo", SIG_CNT, 12);
    tick(1);
    expectSig("R8 new wrap", SIG_CNT, 3);

    // R4: compare above modulo never matches
    wr(3'd2, 200); wr(3'd4, 3); wr(3'd6, 1);
    ocRef = int'(ocPin);
    for (int t = 0; t < 30; t++) begin
      tick(1);
      expectSig("R4 no match above modulo", SIG_OC, ocRef);
    end

    tick(2);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule